// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block is the bus master sequencer for a processor whose low address bits and data share one set of pins. An internal requester presents a read or write with a 20-bit address, 16 bits of write data and a memory-or-I/O select. The sequencer then runs one bus cycle made of four clock states. The first state carries the address and an address strobe. The next two carry data, and the last closes the cycle. It also drives the direction and enable controls that external transceivers need.

The shared lines appear as an output value, an output enable and an input value. The pad ring builds the tri-state driver from these. A slow target stretches the cycle by holding the ready input low. A read returns its data with a one-cycle done pulse. A new request can start a cycle directly from the closing state, so bus cycles may run back to back without an idle gap.

Top module: `mux_bus_seq`

## Requirements
- R1: Each bus cycle passes through its states in the fixed order first (address), second, third (plus any waits), fourth (close). With no wait states, `rsp_done` is high exactly three cycles after the cycle in which `ale` is high.
- R2: In the address state, `ad_oe` is 1, `ad_out` carries address bits 15:0 and `a_hi` carries address bits 19:16.
- R3: `ale` is 1 only in the address state and 0 in every other state, including idle.
- R4: `mem_io` is 1 for a memory access and 0 for an I/O access, and it holds its value from the address state through the close state.
- R5: `dt_r` is 1 for a write and 0 for a read, and it holds its value through the whole cycle.
- R6: In a write, `ad_oe` is 1 and `ad_out` carries the write data from the second state through the close state.
- R7: In a read, `ad_oe` is 0 from the second state through the close state. The value on `ad_in` at the clock edge where ready ends the data phase is returned on `rsp_rdata` together with `rsp_done` in the close state.
- R8: `rd_n` is 0 in reads during the second and third states and during any wait states, and it is 1 in the close state. `wr_n` behaves the same way in writes. The two strobes are never low together.
- R9: `den_n` is 0 from the second state to the end of the data phase in reads, and to the end of the close state in writes. It is 1 in the address state and in idle.
- R10: If `ready_in` is 0 at the end of the third state, wait states repeat it with every strobe held. The cycle moves to the close state only after `ready_in` is sampled 1.
- R11: In idle and after a synchronous reset, even one asserted mid-cycle, `ad_oe`, `ale` and `rsp_done` are 0 and `rd_n`, `wr_n` and `den_n` are 1.
- R12: `req_ready` is 1 only in idle and in the close state. A request seen in the close state starts a new address state on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request accepted this cycle when valid |
| ready_in | input | 1 | Target ready, sampled in the data phase |
| ad_in | input | 16 | Value read back from the shared lines |
| ad_out | output | 16 | Value driven onto the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| a_hi | output | 4 | Upper address lines |
| ale | output | 1 | Address latch strobe |
| mem_io | output | 1 | Memory (1) or I/O (0) indicator |
| dt_r | output | 1 | Transceiver direction, 1 = transmit |
| den_n | output | 1 | Transceiver enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Captured read data |

## Verification
Every output comes from the state register and the latched request through logic with no registers in between. A wrong state therefore shows at the ports in the same cycle. A skipped or repeated state moves the strobes or `rsp_done` by a whole cycle against the `ale` pulse. A wrongly latched address, select or write flag appears on `ad_out`, `mem_io` or `dt_r` the cycle after acceptance. A read captured on the wrong edge returns the deliberately wrong bus value that the wait states present.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_CMD  = 3'd2,
    PH_DATA = 3'd3,
    PH_WAIT = 3'd4,
    PH_END  = 3'd5
  } phase_t;

  // Next phase of a bus cycle given request and target-ready inputs.
  function automatic phase_t phase_next(phase_t cur, logic take, logic rdy);
    phase_t nxt;
    case (cur)
      PH_IDLE: nxt = take ? PH_ADDR : PH_IDLE;
      PH_ADDR: nxt = PH_CMD;
      PH_CMD:  nxt = PH_DATA;
      PH_DATA,
      PH_WAIT: nxt = rdy ? PH_END : PH_WAIT;
      PH_END:  nxt = take ? PH_ADDR : PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  // True in phases where the data strobe is active.
  function automatic logic in_strobe(phase_t p);
    return (p == PH_CMD) || (p == PH_DATA) || (p == PH_WAIT);
  endfunction

  // True in phases where the target ready input decides progress.
  function automatic logic in_sample(phase_t p);
    return (p == PH_DATA) || (p == PH_WAIT);
  endfunction

endpackage

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   req_valid,
  input  logic   ready_in,
  output phase_t phase,
  output logic   accept,
  output logic   open_slot,
  output logic   sample_ok
);

  phase_t phase_q;

  assign open_slot = (phase_q == PH_IDLE) || (phase_q == PH_END);
  assign accept    = req_valid && open_slot;
  assign sample_ok = in_sample(phase_q) && ready_in;
  assign phase     = phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_IDLE;
    else     phase_q <= phase_next(phase_q, accept, ready_in);
  end

  // R1
  addr_then_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    phase_q == PH_ADDR |=> phase_q == PH_CMD);

  // R10
  wait_repeat_chk: assert property (@(posedge clk) disable iff (rst)
    (in_sample(phase_q) && !ready_in) |=> phase_q == PH_WAIT);

  // R12
  chain_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_END && req_valid) |=> phase_q == PH_ADDR);

endmodule

// File: rtl/mbs_latch.sv
module mbs_latch #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              sample_ok,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic              cur_write,
  output logic              cur_mem,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] rdata_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_write <= 1'b0;
      cur_mem   <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (accept) begin
      cur_write <= req_write;
      cur_mem   <= req_mem;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         rdata_q <= '0;
    else if (sample_ok && !cur_write) rdata_q <= ad_in;
  end

endmodule

// File: rtl/mbs_drive.sv
module mbs_drive
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  phase_t            phase,
  input  logic              cur_write,
  input  logic              cur_mem,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [DATA_W-1:0] cur_wdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              mem_io,
  output logic              dt_r,
  output logic              den_n,
  output logic              rd_n,
  output logic              wr_n
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic is_addr, is_strb, is_end, busy;

  assign is_addr = (phase == PH_ADDR);
  assign is_strb = in_strobe(phase);
  assign is_end  = (phase == PH_END);
  assign busy    = (phase != PH_IDLE);

  always_comb begin
    ale    = is_addr;
    ad_oe  = is_addr || (cur_write && (is_strb || is_end));
    ad_out = is_addr ? cur_addr[DATA_W-1:0] : (cur_write ? cur_wdata : '0);
    a_hi   = is_addr ? cur_addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
    rd_n   = !(is_strb && !cur_write);
    wr_n   = !(is_strb && cur_write);
    den_n  = !(is_strb || (is_end && cur_write));
    mem_io = busy && cur_mem;
    dt_r   = busy && cur_write;
  end

  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  // R9
  den_after_ale_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(den_n) |-> $past(ale));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_mem,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  input  logic              ready_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] a_hi,
  output logic              ale,
  output logic              mem_io,
  output logic              dt_r,
  output logic              den_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  phase_t            phase;
  logic              accept, open_slot, sample_ok;
  logic              cur_write, cur_mem;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata, rdata_q;

  mbs_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .ready_in  (ready_in),
    .phase     (phase),
    .accept    (accept),
    .open_slot (open_slot),
    .sample_ok (sample_ok)
  );

  mbs_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .sample_ok (sample_ok),
    .req_write (req_write),
    .req_mem   (req_mem),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .cur_write (cur_write),
    .cur_mem   (cur_mem),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .rdata_q   (rdata_q)
  );

  mbs_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drive (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .cur_write (cur_write),
    .cur_mem   (cur_mem),
    .cur_addr  (cur_addr),
    .cur_wdata (cur_wdata),
    .ad_out    (ad_out),
    .ad_oe     (ad_oe),
    .a_hi      (a_hi),
    .ale       (ale),
    .mem_io    (mem_io),
    .dt_r      (dt_r),
    .den_n     (den_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
  );

  assign req_ready = open_slot;
  assign rsp_done  = (phase == PH_END);
  assign rsp_rdata = rdata_q;

  // R4
  select_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> ($stable(mem_io) && $stable(dt_r)));

  // R1
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_done) |-> $past(!rd_n || !wr_n));

endmodule

// File: tb/mux_bus_seq_bench.sv
module mux_bus_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready;
  logic        ready_in = 1'b0;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  a_hi;
  logic        ale, mem_io, dt_r, den_n, rd_n, wr_n, rsp_done;
  logic [15:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_mem(req_mem), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .ready_in(ready_in), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
    .mem_io(mem_io), .dt_r(dt_r), .den_n(den_n), .rd_n(rd_n),
    .wr_n(wr_n), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_outputs(input string tag);
    chk(tag, "ale", ale, 0);
    chk(tag, "ad_oe", ad_oe, 0);
    chk(tag, "rd_n", rd_n, 1);
    chk(tag, "wr_n", wr_n, 1);
    chk(tag, "den_n", den_n, 1);
    chk(tag, "rsp_done", rsp_done, 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_outputs("R11");
    chk("R12", "req_ready idle", req_ready, 1);
  endtask

  // Address state checks common to reads and writes.
  task automatic check_addr(input logic [19:0] a, input logic m, input logic w);
    chk("R3", "ale in address state", ale, 1);
    chk("R2", "ad_oe", ad_oe, 1);
    chk("R2", "ad_out low address", ad_out, a[15:0]);
    chk("R2", "a_hi", a_hi, a[19:16]);
    chk("R4", "mem_io", mem_io, m);
    chk("R5", "dt_r", dt_r, w);
    chk("R9", "den_n in address state", den_n, 1);
    chk("R8", "strobes in address state", {rd_n, wr_n}, 2'b11);
    chk("R12", "req_ready busy", req_ready, 0);
  endtask

  task automatic t_read(input logic [19:0] a, input logic m,
                        input logic [15:0] d, input int waits);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_mem = m; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    check_addr(a, m, 0);
    @(negedge clk);
    chk("R3", "ale second state", ale, 0);
    chk("R7", "ad released", ad_oe, 0);
    chk("R8", "rd_n low", rd_n, 0);
    chk("R8", "wr_n high", wr_n, 1);
    chk("R9", "den_n low", den_n, 0);
    chk("R4", "mem_io held", mem_io, m);
    for (int w = waits; w >= 0; w--) begin
      @(negedge clk);
      chk("R10", "rd_n held in data phase", rd_n, 0);
      chk("R10", "den_n held in data phase", den_n, 0);
      chk("R1", "no early done", rsp_done, 0);
      chk("R7", "ad released data phase", ad_oe, 0);
      ready_in = (w == 0);
      ad_in    = (w == 0) ? d : ~d;
    end
    @(negedge clk);
    ready_in = 0; ad_in = 16'h0bad;
    chk("R1", "done in close state", rsp_done, 1);
    chk("R7", "read data", rsp_rdata, d);
    chk("R7", "ad released close", ad_oe, 0);
    chk("R8", "rd_n released", rd_n, 1);
    chk("R9", "den_n off read close", den_n, 1);
    chk("R4", "mem_io close", mem_io, m);
    chk("R5", "dt_r read", dt_r, 0);
    chk("R12", "req_ready close", req_ready, 1);
    @(negedge clk);
    idle_outputs("R11");
  endtask

  task automatic t_write(input logic [19:0] a, input logic m,
                         input logic [15:0] d, input int waits);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_mem = m; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    check_addr(a, m, 1);
    @(negedge clk);
    chk("R6", "ad_oe second", ad_oe, 1);
    chk("R6", "wdata second", ad_out, d);
    chk("R8", "wr_n low", wr_n, 0);
    chk("R8", "rd_n high", rd_n, 1);
    chk("R9", "den_n low", den_n, 0);
    for (int w = waits; w >= 0; w--) begin
      @(negedge clk);
      chk("R10", "wr_n held", wr_n, 0);
      chk("R6", "wdata held", ad_out, d);
      chk("R1", "no early done", rsp_done, 0);
      ready_in = (w == 0);
    end
    @(negedge clk);
    ready_in = 0;
    chk("R1", "done in close", rsp_done, 1);
    chk("R6", "wdata close", ad_out, d);
    chk("R6", "ad_oe close", ad_oe, 1);
    chk("R8", "wr_n released", wr_n, 1);
    chk("R9", "den_n held write close", den_n, 0);
    chk("R5", "dt_r write", dt_r, 1);
    chk("R4", "mem_io close", mem_io, m);
    @(negedge clk);
    idle_outputs("R11");
  endtask

  task automatic t_chain();
    @(negedge clk);
    req_valid = 1; req_write = 1; req_mem = 1; req_addr = 20'h3_1111;
    req_wdata = 16'h5a5a;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    req_valid = 1; req_addr = 20'h7_2222; req_write = 0; req_mem = 0;
    chk("R12", "req_ready second state", req_ready, 0);
    @(negedge clk);
    req_valid = 0;
    ready_in = 1;
    @(negedge clk);
    ready_in = 0;
    req_valid = 1;
    chk("R12", "req_ready close", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R12", "new address state follows close", ale, 1);
    chk("R12", "new address", ad_out, 16'h2222);
    chk("R12", "new a_hi", a_hi, 4'h7);
    chk("R5", "new dt_r", dt_r, 0);
    @(negedge clk);
    @(negedge clk);
    ready_in = 1; ad_in = 16'h1357;
    @(negedge clk);
    ready_in = 0;
    chk("R7", "chained read data", rsp_rdata, 16'h1357);
    @(negedge clk);
    idle_outputs("R11");
  endtask

  task automatic t_mid_reset();
    @(negedge clk);
    req_valid = 1; req_write = 0; req_mem = 1; req_addr = 20'h0_0042;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    chk("R8", "rd_n low before reset", rd_n, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    idle_outputs("R11");
    chk("R11", "mem_io cleared", mem_io, 0);
    chk("R12", "req_ready after reset", req_ready, 1);
  endtask

  initial begin
    do_reset();
    t_read (20'hA_BCDE, 1'b1, 16'hC0DE, 0);
    t_read (20'h0_0F0F, 1'b0, 16'h1234, 3);
    t_write(20'h5_8001, 1'b1, 16'hBEEF, 0);
    t_write(20'hF_FFFE, 1'b0, 16'h00FF, 2);
    t_chain();
    t_mid_reset();
    done_flag = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(posedge clk);
      if (done_flag) break;
    end
    if (!done_flag) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule